// File: doc/BRIEF.md
# Serial Configuration Memory Loader

After reset this block fetches a fixed number of configuration words from an external three-wire serial memory. It stores them in a small register file that the rest of the device reads. It drives the memory's chip enable, shift clock and serial output, and it samples the memory's serial input. The shift clock is the system clock divided by 64. Each word is fetched with its own read transaction: a start bit, a two-bit read opcode and an address, all sent most significant bit first, followed by a sixteen-bit reply.

A strap input chooses where the configuration comes from. If the strap selects the built-in set, no transaction takes place and the built-in values are published at once. The shift clock pin and the serial output pin can each be given to a general-purpose output value by an enable bit from a control register. The chip enable pin always keeps its memory function.

Top module: `cfg_eeprom_loader`

## Requirements
- R1: While reset is high and on the first cycle after it, `ee_ce` and `cfg_ready` are low.
- R2: While `ee_ce` is high, `ee_sck` has a period of exactly 64 clock cycles, with 32 cycles high and 32 cycles low. While `ee_ce` is low, `ee_sck` is low.
- R3: `ee_sdo` never changes while `ee_sck` is high, and it never changes on the edge where `ee_sck` rises. It changes only on the clock edge where `ee_sck` falls, or when chip enable goes high.
- R4: Each transaction sends 11 bits on `ee_sdo`, each launched for one shift-clock period: the bits 1, 1, 0, then the 8-bit address MSB first. The address for word i is START_ADDR + i, where START_ADDR defaults to 0x10.
- R5: After the 11 command bits, the block receives 16 data bits MSB first. It samples `ee_sdi` at each of the next 16 falling shift-clock edges. A transaction therefore spans exactly 27 shift-clock rises.
- R6: Before every rise of `ee_ce`, including the first after reset, `ee_ce` has been low for at least 64 clock cycles.
- R7: The block reads words 0 to NWORDS-1 in increasing order and then raises `cfg_ready`. `cfg_ready` then stays high and `ee_ce` stays low. Word i appears on `cfg_words[16*i +: 16]`.
- R8: While `cfg_ready` is low, word i of `cfg_words` reads the built-in default 0xA500 + i.
- R9: If `cfg_src_int` is 1 during the first cycle after reset, no transaction takes place. In that case `cfg_ready` goes high within two cycles, and `cfg_words` keeps the defaults.
- R10: Bit 0 of `gpo_en` routes `gpo_val[0]` to `ee_sck`, and bit 1 routes `gpo_val[1]` to `ee_sdo`. A clear enable bit leaves the pin with its memory function.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_src_int | input | 1 | Strap: 1 uses the built-in set, 0 loads from memory |
| gpo_en | input | 2 | Per-pin output takeover: bit 0 for the clock pin, bit 1 for the data-out pin |
| gpo_val | input | 2 | General-purpose output values for the two pins |
| ee_sdi | input | 1 | Serial data from the memory |
| ee_ce | output | 1 | Memory chip enable, active high |
| ee_sck | output | 1 | Shift clock pin |
| ee_sdo | output | 1 | Serial command and address pin |
| cfg_words | output | NWORDS*16 | Configuration words, word i at bits 16*i and up |
| cfg_ready | output | 1 | High once the configuration is final |

## Verification
The clock-shape and data-hold properties assume that `gpo_en` stays at zero, and unchanged, for the whole time the pins carry the memory function. The stimulus therefore changes the takeover bits only after `cfg_ready` has risen, or under the strap. The memory model changes `ee_sdi` only on rising shift-clock edges, so the data is stable at each falling-edge sample. Word contents come from a seeded random source, mixed with all-ones, all-zeros and edge-bit patterns.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    localparam int WORD_W = 16;
    localparam int HDR_W  = 3;
    localparam int IDX_W  = 8;

    // start bit followed by the two-bit read opcode
    localparam logic [HDR_W-1:0]  RD_HDR    = 3'b110;
    localparam logic [WORD_W-1:0] DFLT_BASE = 16'hA500;

    typedef enum logic [2:0] {
        LD_START,
        LD_GAP,
        LD_SEND,
        LD_RECV,
        LD_DONE
    } ld_state_e;

    typedef struct packed {
        logic              we;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] data;
    } wr_req_t;

    function automatic logic [WORD_W-1:0] dflt_word(input int unsigned idx);
        return DFLT_BASE + WORD_W'(idx);
    endfunction

endpackage

// File: rtl/cfgld_clkdiv.sv
module cfgld_clkdiv #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic phase_hi,
    output logic end_tick
);
    localparam int CW = $clog2(DIV);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // second half of every period is the high phase
    assign phase_hi = cnt[CW-1];
    assign end_tick = run && (cnt == CW'(DIV - 1));

endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
    import cfgld_pkg::*;
#(
    parameter int NWORDS = 4,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] START_ADDR = 8'h10
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    use_internal,
    input  logic    end_tick,
    input  logic    sdi,
    output logic    run,
    output logic    shifting,
    output logic    sdo,
    output wr_req_t wr,
    output logic    done
);
    localparam int TX_W   = HDR_W + ADDR_W;
    localparam int BC_MAX = (TX_W > WORD_W) ? TX_W : WORD_W;
    localparam int BC_W   = $clog2(BC_MAX);
    localparam int WI_W   = $clog2(NWORDS + 1);

    ld_state_e         state;
    logic [BC_W-1:0]   bit_cnt;
    logic [WI_W-1:0]   word_idx;
    logic [TX_W-1:0]   tx_sh;
    logic [WORD_W-2:0] rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= LD_START;
            bit_cnt  <= '0;
            word_idx <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            wr       <= '0;
        end else begin
            wr.we <= 1'b0;
            unique case (state)
                LD_START: begin
                    state <= use_internal ? LD_DONE : LD_GAP;
                end
                LD_GAP: begin
                    if (end_tick) begin
                        tx_sh   <= {RD_HDR, START_ADDR + ADDR_W'(word_idx)};
                        bit_cnt <= '0;
                        state   <= LD_SEND;
                    end
                end
                LD_SEND: begin
                    if (end_tick) begin
                        tx_sh <= tx_sh << 1;
                        if (bit_cnt == BC_W'(TX_W - 1)) begin
                            bit_cnt <= '0;
                            state   <= LD_RECV;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                LD_RECV: begin
                    if (end_tick) begin
                        rx_sh <= {rx_sh[WORD_W-3:0], sdi};
                        if (bit_cnt == BC_W'(WORD_W - 1)) begin
                            wr.we    <= 1'b1;
                            wr.idx   <= IDX_W'(word_idx);
                            wr.data  <= {rx_sh, sdi};
                            bit_cnt  <= '0;
                            word_idx <= word_idx + 1'b1;
                            state    <= (word_idx == WI_W'(NWORDS - 1)) ? LD_DONE : LD_GAP;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                LD_DONE: begin
                    state <= LD_DONE;
                end
                default: begin
                    state <= LD_START;
                end
            endcase
        end
    end

    assign shifting = (state == LD_SEND) || (state == LD_RECV);
    assign run      = shifting || (state == LD_GAP);
    assign sdo      = (state == LD_SEND) && tx_sh[TX_W-1];
    // hold off publication until the final word has landed in the file
    assign done     = (state == LD_DONE) && !wr.we;

endmodule

// File: rtl/cfgld_regfile.sv
module cfgld_regfile
    import cfgld_pkg::*;
#(
    parameter int NWORDS = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  wr_req_t                  wr,
    input  logic                     done,
    output logic [NWORDS*WORD_W-1:0] words
);
    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        logic [WORD_W-1:0] q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= dflt_word(g);
            end else if (wr.we && (wr.idx == IDX_W'(g))) begin
                q <= wr.data;
            end
        end

        assign words[g*WORD_W +: WORD_W] = done ? q : dflt_word(g);
    end

endmodule

// File: rtl/cfgld_pinmux.sv
module cfgld_pinmux #(
    parameter int NPINS = 2
) (
    input  logic [NPINS-1:0] gpo_en,
    input  logic [NPINS-1:0] gpo_val,
    input  logic [NPINS-1:0] core,
    output logic [NPINS-1:0] pin
);
    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        assign pin[g] = gpo_en[g] ? gpo_val[g] : core[g];
    end

endmodule

// File: rtl/cfg_eeprom_loader.sv
module cfg_eeprom_loader
    import cfgld_pkg::*;
#(
    parameter int NWORDS = 4,
    parameter int DIV    = 64,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] START_ADDR = 8'h10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_src_int,
    input  logic [1:0]               gpo_en,
    input  logic [1:0]               gpo_val,
    input  logic                     ee_sdi,
    output logic                     ee_ce,
    output logic                     ee_sck,
    output logic                     ee_sdo,
    output logic [NWORDS*WORD_W-1:0] cfg_words,
    output logic                     cfg_ready
);
    logic    run;
    logic    shifting;
    logic    phase_hi;
    logic    end_tick;
    logic    sdo_core;
    logic    done_int;
    wr_req_t wr;
    logic [1:0] core_pins;
    logic [1:0] out_pins;

    cfgld_clkdiv #(.DIV(DIV)) u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .phase_hi (phase_hi),
        .end_tick (end_tick)
    );

    cfgld_seq #(
        .NWORDS     (NWORDS),
        .ADDR_W     (ADDR_W),
        .START_ADDR (START_ADDR)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .use_internal (cfg_src_int),
        .end_tick     (end_tick),
        .sdi          (ee_sdi),
        .run          (run),
        .shifting     (shifting),
        .sdo          (sdo_core),
        .wr           (wr),
        .done         (done_int)
    );

    cfgld_regfile #(.NWORDS(NWORDS)) u_file (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr),
        .done  (done_int),
        .words (cfg_words)
    );

    assign core_pins = {sdo_core, shifting && phase_hi};

    cfgld_pinmux #(.NPINS(2)) u_mux (
        .gpo_en  (gpo_en),
        .gpo_val (gpo_val),
        .core    (core_pins),
        .pin     (out_pins)
    );

    assign ee_sck    = out_pins[0];
    assign ee_sdo    = out_pins[1];
    assign ee_ce     = shifting;
    assign cfg_ready = done_int;

endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker
    import cfgld_pkg::*;
#(
    parameter int NWORDS = 4,
    parameter int DIV    = 64
) (
    input logic                     clk,
    input logic                     rst,
    input logic [1:0]               gpo_en,
    input logic                     ee_ce,
    input logic                     ee_sck,
    input logic                     ee_sdo,
    input logic [NWORDS*WORD_W-1:0] cfg_words,
    input logic                     cfg_ready
);
    localparam int HALF = DIV / 2;
    localparam int CW   = $clog2(DIV) + 1;

    logic [CW-1:0] hi_cnt;
    logic [CW-1:0] lo_cnt;
    logic [NWORDS*WORD_W-1:0] dflt_all;
    logic mem_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
            lo_cnt <= '0;
        end else begin
            hi_cnt <= ee_sck ? ((hi_cnt == CW'(DIV)) ? hi_cnt : hi_cnt + 1'b1) : '0;
            lo_cnt <= ee_ce ? '0 : ((lo_cnt == CW'(DIV)) ? lo_cnt : lo_cnt + 1'b1);
        end
    end

    always_comb begin
        for (int i = 0; i < NWORDS; i++) begin
            dflt_all[i*WORD_W +: WORD_W] = dflt_word(i);
        end
    end

    assign mem_mode = (gpo_en == 2'b00);

    assert_sck_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_mode && !ee_ce) |-> !ee_sck);

    assert_sck_high_len_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_mode && $stable(gpo_en) && $fell(ee_sck)) |-> (hi_cnt == CW'(HALF)));

    assert_sdo_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_mode && $stable(gpo_en) && ee_sck) |-> $stable(ee_sdo));

    assert_ce_gap_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ee_ce) |-> (lo_cnt >= CW'(DIV)));

    assert_ready_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        cfg_ready |=> cfg_ready);

    assert_ready_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        cfg_ready |-> !ee_ce);

    assert_defaults_R8: assert property (@(posedge clk) disable iff (rst)
        !cfg_ready |-> (cfg_words == dflt_all));

endmodule

bind cfg_eeprom_loader cfgld_checker #(
    .NWORDS (NWORDS),
    .DIV    (DIV)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .gpo_en    (gpo_en),
    .ee_ce     (ee_ce),
    .ee_sck    (ee_sck),
    .ee_sdo    (ee_sdo),
    .cfg_words (cfg_words),
    .cfg_ready (cfg_ready)
);

// File: tb/cfg_eeprom_loader_test.sv
module cfg_eeprom_loader_test;

    localparam int CLK_PERIOD = 10;
    localparam int NW = 4;
    localparam int DV = 64;
    localparam logic [7:0] SA = 8'h10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_src_int = 1'b0;
    logic [1:0] gpo_en = 2'b00;
    logic [1:0] gpo_val = 2'b00;
    logic ee_sdi = 1'b0;
    logic ee_ce, ee_sck, ee_sdo, cfg_ready;
    logic [NW*16-1:0] cfg_words;

    cfg_eeprom_loader #(
        .NWORDS(NW), .DIV(DV), .ADDR_W(8), .START_ADDR(SA)
    ) uut (
        .clk(clk), .rst(rst), .cfg_src_int(cfg_src_int),
        .gpo_en(gpo_en), .gpo_val(gpo_val), .ee_sdi(ee_sdi),
        .ee_ce(ee_ce), .ee_sck(ee_sck), .ee_sdo(ee_sdo),
        .cfg_words(cfg_words), .cfg_ready(cfg_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;

    logic [15:0] mem [256];
    logic [10:0] cmd_sh;
    logic [10:0] cmd_log [16];
    int  bitk = 0;
    int  n_cmds = 0;
    int  ce_rises = 0;
    int  per_err = 0, sdo_err = 0, gap_err = 0, bits_err = 0;
    bit  in_txn = 1'b0;
    time last_rise = 0;
    time last_ce_fall = 0;
    logic prev_sdo = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [NW*16-1:0] exp_defaults();
        logic [NW*16-1:0] v;
        for (int i = 0; i < NW; i++) v[i*16 +: 16] = 16'hA500 + 16'(i);
        return v;
    endfunction

    function automatic logic [10:0] exp_cmd(input int i);
        return {3'b110, 8'(SA + 8'(i))};
    endfunction

    // serial memory model: samples command bits and launches data on rising clock
    always @(posedge ee_sck) begin
        if (ee_ce && gpo_en == 2'b00) begin
            if (bitk > 0 && ($time - last_rise) != DV*CLK_PERIOD) per_err++;
            last_rise = $time;
            if (bitk < 11) cmd_sh = {cmd_sh[9:0], ee_sdo};
            else if (bitk < 27) ee_sdi = mem[cmd_sh[7:0]][26 - bitk];
            bitk++;
        end
    end

    always @(posedge ee_ce) begin
        ce_rises++;
        in_txn = 1'b1;
        if (($time - last_ce_fall) < DV*CLK_PERIOD) gap_err++;
        bitk = 0;
    end

    always @(negedge ee_ce) begin
        if (in_txn) begin
            in_txn = 1'b0;
            if (bitk != 27) bits_err++;
            if (n_cmds < 16) cmd_log[n_cmds] = cmd_sh;
            n_cmds++;
            last_ce_fall = $time;
            ee_sdi = 1'b0;
        end
    end

    // data-out may only move while the clock is low and not at its rise
    always @(negedge clk) begin
        if (!rst && gpo_en == 2'b00 && ee_sck && ee_sdo !== prev_sdo) sdo_err++;
        prev_sdo = ee_sdo;
    end

    task automatic do_reset(input bit strap);
        rst = 1'b1;
        cfg_src_int = strap;
        gpo_en = 2'b00;
        gpo_val = 2'b00;
        n_cmds = 0; ce_rises = 0;
        per_err = 0; sdo_err = 0; gap_err = 0; bits_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        last_ce_fall = $time;
        chk(ee_ce == 1'b0, "R1", "chip enable after reset", 64'(ee_ce), 0);
        chk(cfg_ready == 1'b0, "R1", "ready after reset", 64'(cfg_ready), 0);
    endtask

    task automatic gpo_checks();
        for (int k = 0; k < 6; k++) begin
            logic [1:0] en, val;
            en  = 2'($urandom);
            val = 2'($urandom);
            if (k == 0) begin en = 2'b11; val = 2'b11; end
            gpo_en = en;
            gpo_val = val;
            @(negedge clk);
            chk(ee_sck == (en[0] ? val[0] : 1'b0), "R10", "clock pin", 64'(ee_sck),
                64'(en[0] ? val[0] : 1'b0));
            chk(ee_sdo == (en[1] ? val[1] : 1'b0), "R10", "data-out pin", 64'(ee_sdo),
                64'(en[1] ? val[1] : 1'b0));
        end
        gpo_en = 2'b00;
        gpo_val = 2'b00;
        @(negedge clk);
    endtask

    task automatic run_load(input int pattern);
        int n;
        for (int a = 0; a < 256; a++) mem[a] = 16'($urandom);
        for (int i = 0; i < NW; i++) begin
            if (pattern == 1) mem[SA + 8'(i)] = 16'hFFFF;
            if (pattern == 2) mem[SA + 8'(i)] = (i == 0) ? 16'h8001 : 16'h0000;
        end
        do_reset(1'b0);
        chk(cfg_words == exp_defaults(), "R8", "words right after reset", cfg_words, exp_defaults());
        repeat (1500) @(negedge clk);
        chk(cfg_ready == 1'b0, "R8", "ready mid-load", 64'(cfg_ready), 0);
        chk(cfg_words == exp_defaults(), "R8", "words mid-load", cfg_words, exp_defaults());
        n = 0;
        while (!cfg_ready && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(cfg_ready == 1'b1, "R7", "ready after load", 64'(cfg_ready), 1);
        repeat (200) @(negedge clk);
        chk(ce_rises == NW, "R7", "transaction count", 64'(ce_rises), NW);
        chk(n_cmds == NW, "R7", "completed transactions", 64'(n_cmds), NW);
        for (int i = 0; i < NW && i < n_cmds; i++) begin
            chk(cmd_log[i] == exp_cmd(i), "R4", "command bits", 64'(cmd_log[i]), 64'(exp_cmd(i)));
            chk(cfg_words[i*16 +: 16] == mem[SA + 8'(i)], "R5", "loaded word",
                64'(cfg_words[i*16 +: 16]), 64'(mem[SA + 8'(i)]));
        end
        chk(per_err == 0, "R2", "clock period violations", 64'(per_err), 0);
        chk(sdo_err == 0, "R3", "data-out moves with clock high", 64'(sdo_err), 0);
        chk(bits_err == 0, "R5", "transactions of wrong length", 64'(bits_err), 0);
        chk(gap_err == 0, "R6", "short chip-enable gaps", 64'(gap_err), 0);
        chk(ee_ce == 1'b0 && cfg_ready == 1'b1, "R7", "idle after done",
            64'({ee_ce, cfg_ready}), 64'(2'b01));
        chk(ee_sck == 1'b0, "R2", "clock idle low", 64'(ee_sck), 0);
        gpo_checks();
        chk(cfg_ready == 1'b1, "R7", "ready held through pin takeover", 64'(cfg_ready), 1);
    endtask

    initial begin
        void'($urandom(32'h5EED_0C1F));
        run_load(0);
        run_load(1);
        run_load(2);
        run_load(0);
        // strap selects the built-in set
        for (int a = 0; a < 256; a++) mem[a] = 16'($urandom);
        do_reset(1'b1);
        repeat (2) @(negedge clk);
        chk(cfg_ready == 1'b1, "R9", "ready under strap", 64'(cfg_ready), 1);
        chk(cfg_words == exp_defaults(), "R9", "defaults under strap", cfg_words, exp_defaults());
        repeat (500) @(negedge clk);
        chk(ce_rises == 0, "R9", "no transaction under strap", 64'(ce_rises), 0);
        chk(cfg_words == exp_defaults(), "R9", "defaults kept under strap", cfg_words, exp_defaults());
        gpo_checks();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R7 watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule